// File: doc/BRIEF.md
# Shared-Pin Scan Test Port Controller

This block is a boundary-scan test access port controller whose scan pads can also serve as ordinary user I/O. A 16-state controller advances on each rising edge of the test clock, steered by the mode-select input. A four-bit instruction register chooses between a one-bit bypass path and a 32-bit identification path. Serial data leaves on the falling edge of the test clock, and the output is enabled only while a register is being shifted.

An ownership latch decides whether the test clock, data-in and data-out pads belong to the scan logic or to the user design. In flexible mode, the pads are claimed when the controller leaves its reset state. They are handed back when the controller re-enters that state. In dedicated mode, the pads always belong to the scan logic. A second configuration input decides whether the reset pad is kept as an asynchronous active-low scan reset or is left to the user. The per-pad select outputs drive the pad multiplexers outside this block.

Top module: `scan_port_ctrl`

## Requirements
- R1: While `porN` is low the controller sits in Test-Logic-Reset (`tapState` = 4'hF) and `tdoEn` is 0. In flexible mode, `tckSel`, `tdiSel` and `tdoSel` are 0 (user ownership). The instruction register holds IDCODE.
- R2: State codes are: 4'hF Test-Logic-Reset, 4'hC Run-Test/Idle, 4'h7 Select-DR, 4'h6 Capture-DR, 4'h2 Shift-DR, 4'h1 Exit1-DR, 4'h3 Pause-DR, 4'h0 Exit2-DR, 4'h5 Update-DR, 4'h4 Select-IR, 4'hE Capture-IR, 4'hA Shift-IR, 4'h9 Exit1-IR, 4'hB Pause-IR, 4'h8 Exit2-IR, 4'hD Update-IR. Transitions follow the standard test-port graph, one per `tck` rising edge.
- R3: In flexible mode, a low `tms` sampled on a `tck` rising edge sets `tckSel`, `tdiSel` and `tdoSel` to 1 (scan ownership) after that edge. A high `tms` in Test-Logic-Reset keeps user ownership. The three selects always agree.
- R4: In flexible mode, scan ownership holds in every state other than Test-Logic-Reset. It drops to user ownership on the same edge that enters Test-Logic-Reset.
- R5: Five consecutive `tck` rising edges with `tms` high reach Test-Logic-Reset from any state. From Shift-IR, four such edges are not enough.
- R6: After reset, the data path shifts out `ID_VALUE` least significant bit first, 32 bits in Shift-DR.
- R7: With opcode 4'b1111 (BYPASS) in the instruction register, Shift-DR outputs a 0 first and then each `tdi` bit delayed by one `tck` cycle. Any opcode other than 4'b0001 (IDCODE) selects bypass.
- R8: Capture-IR loads 4'b0001, which is shifted out least significant bit first. The shifted-in value takes effect on leaving Update-IR.
- R9: `tdo` and `tdoEn` change on the `tck` falling edge. `tdoEn` is 1 only while the state is Shift-DR or Shift-IR.
- R10: With `cfgTrstReserved` = 1, a low `trstN` forces Test-Logic-Reset at once without a `tck` edge. This releases the pads in flexible mode and clears `tdoEn`. `trstSel` is 1.
- R11: With `cfgTrstReserved` = 0, `trstN` has no effect on the controller and `trstSel` is 0.
- R12: With `cfgDedicated` = 1, `tckSel`, `tdiSel` and `tdoSel` are 1 in every state, including Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| trstN | input | 1 | Scan reset pad, active low, used only when reserved |
| tms | input | 1 | Mode select, sampled on tck rise |
| tdi | input | 1 | Serial data in, sampled on tck rise |
| cfgDedicated | input | 1 | 1 = dedicated test mode, 0 = flexible |
| cfgTrstReserved | input | 1 | 1 = reset pad reserved as scan reset |
| tdo | output | 1 | Serial data out, changes on tck fall |
| tdoEn | output | 1 | Output enable for tdo pad |
| tckSel | output | 1 | 1 = tck pad owned by scan logic |
| tdiSel | output | 1 | 1 = tdi pad owned by scan logic |
| tdoSel | output | 1 | 1 = tdo pad owned by scan logic |
| trstSel | output | 1 | 1 = reset pad owned by scan logic |
| tapState | output | 4 | Current controller state code |

## Verification
The state code and the ownership selects settle on the same `tck` rising edge that samples `tms`. Each directed step drives `tms`/`tdi` just after a falling edge and reads results 1 ns after the following rising edge. Serial output and its enable are due on the falling edge that follows entry into a shift state, so shifted bits are read 1 ns after each falling edge and before the next rising edge moves the register. The asynchronous reset takes effect with no clock edge, so it is checked 1 ns after `trstN` falls, halfway between edges.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_EX2DR   = 4'h0,
    ST_EX1DR   = 4'h1,
    ST_SHDR    = 4'h2,
    ST_PAUSEDR = 4'h3,
    ST_SELIR   = 4'h4,
    ST_UPDDR   = 4'h5,
    ST_CAPDR   = 4'h6,
    ST_SELDR   = 4'h7,
    ST_EX2IR   = 4'h8,
    ST_EX1IR   = 4'h9,
    ST_SHIR    = 4'hA,
    ST_PAUSEIR = 4'hB,
    ST_IDLE    = 4'hC,
    ST_UPDIR   = 4'hD,
    ST_CAPIR   = 4'hE,
    ST_TLR     = 4'hF
  } tapStateT;

  // strobes from control to datapath, all valid for the current state
  typedef struct packed {
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic shiftAny;
  } tapStrobeT;

endpackage

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic      tck,
  input  logic      rstN,
  input  logic      tms,
  output tapStateT  state,
  output logic      scanOwn,
  output tapStrobeT strobe
);

  tapStateT nextState;

  always_comb begin
    case (state)
      ST_TLR:     nextState = tms ? ST_TLR   : ST_IDLE;
      ST_IDLE:    nextState = tms ? ST_SELDR : ST_IDLE;
      ST_SELDR:   nextState = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR:   nextState = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:    nextState = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR:   nextState = tms ? ST_UPDDR : ST_PAUSEDR;
      ST_PAUSEDR: nextState = tms ? ST_EX2DR : ST_PAUSEDR;
      ST_EX2DR:   nextState = tms ? ST_UPDDR : ST_SHDR;
      ST_UPDDR:   nextState = tms ? ST_SELDR : ST_IDLE;
      ST_SELIR:   nextState = tms ? ST_TLR   : ST_CAPIR;
      ST_CAPIR:   nextState = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:    nextState = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR:   nextState = tms ? ST_UPDIR : ST_PAUSEIR;
      ST_PAUSEIR: nextState = tms ? ST_EX2IR : ST_PAUSEIR;
      ST_EX2IR:   nextState = tms ? ST_UPDIR : ST_SHIR;
      ST_UPDIR:   nextState = tms ? ST_SELDR : ST_IDLE;
      default:    nextState = ST_TLR;
    endcase
  end

  // ownership latch: claimed by a low tms, released on entry to reset state
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_TLR;
      scanOwn <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState == ST_TLR) scanOwn <= 1'b0;
      else if (!tms)           scanOwn <= 1'b1;
    end
  end

  always_comb begin
    strobe.captureIr = (state == ST_CAPIR);
    strobe.shiftIr   = (state == ST_SHIR);
    strobe.updateIr  = (state == ST_UPDIR);
    strobe.captureDr = (state == ST_CAPDR);
    strobe.shiftDr   = (state == ST_SHDR);
    strobe.shiftAny  = (state == ST_SHDR) || (state == ST_SHIR);
  end

endmodule

// File: rtl/scan_tap_dp.sv
module scan_tap_dp
  import scan_tap_pkg::*;
#(
  parameter int                  IR_WIDTH  = 4,
  parameter int                  ID_WIDTH  = 32,
  parameter logic [ID_WIDTH-1:0] ID_VALUE  = 32'h4A3790C5,
  parameter logic [IR_WIDTH-1:0] OP_IDCODE = 4'b0001
)(
  input  logic      tck,
  input  logic      rstN,
  input  logic      tdi,
  input  tapStrobeT strobe,
  output logic      tdo,
  output logic      tdoEn
);

  localparam logic [IR_WIDTH-1:0] IR_CAPTURE = IR_WIDTH'(1);

  logic [IR_WIDTH-1:0] irShift;
  logic [IR_WIDTH-1:0] irActive;
  logic [ID_WIDTH-1:0] idShift;
  logic                bypassBit;
  logic                serialOut;
  logic                idSelected;

  assign idSelected = (irActive == OP_IDCODE);

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      irShift   <= '0;
      irActive  <= OP_IDCODE;
      idShift   <= ID_VALUE;
      bypassBit <= 1'b0;
    end else begin
      if (strobe.captureIr)     irShift <= IR_CAPTURE;
      else if (strobe.shiftIr)  irShift <= {tdi, irShift[IR_WIDTH-1:1]};
      if (strobe.updateIr)      irActive <= irShift;
      if (strobe.captureDr) begin
        idShift   <= ID_VALUE;
        bypassBit <= 1'b0;
      end else if (strobe.shiftDr) begin
        idShift   <= {tdi, idShift[ID_WIDTH-1:1]};
        bypassBit <= tdi;
      end
    end
  end

  always_comb begin
    if (strobe.shiftIr)  serialOut = irShift[0];
    else if (idSelected) serialOut = idShift[0];
    else                 serialOut = bypassBit;
  end

  // output stage launches on the falling edge
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialOut;
      tdoEn <= strobe.shiftAny;
    end
  end

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_tap_pkg::*;
#(
  parameter int                  IR_WIDTH  = 4,
  parameter int                  ID_WIDTH  = 32,
  parameter logic [ID_WIDTH-1:0] ID_VALUE  = 32'h4A3790C5,
  parameter logic [IR_WIDTH-1:0] OP_IDCODE = 4'b0001
)(
  input  logic       tck,
  input  logic       porN,
  input  logic       trstN,
  input  logic       tms,
  input  logic       tdi,
  input  logic       cfgDedicated,
  input  logic       cfgTrstReserved,
  output logic       tdo,
  output logic       tdoEn,
  output logic       tckSel,
  output logic       tdiSel,
  output logic       tdoSel,
  output logic       trstSel,
  output logic [3:0] tapState
);

  logic      rstN;
  logic      scanOwn;
  tapStateT  state;
  tapStrobeT strobe;

  assign rstN = porN & (trstN | ~cfgTrstReserved);

  scan_tap_ctrl u_ctrl (
    .tck     (tck),
    .rstN    (rstN),
    .tms     (tms),
    .state   (state),
    .scanOwn (scanOwn),
    .strobe  (strobe)
  );

  scan_tap_dp #(
    .IR_WIDTH  (IR_WIDTH),
    .ID_WIDTH  (ID_WIDTH),
    .ID_VALUE  (ID_VALUE),
    .OP_IDCODE (OP_IDCODE)
  ) u_dp (
    .tck    (tck),
    .rstN   (rstN),
    .tdi    (tdi),
    .strobe (strobe),
    .tdo    (tdo),
    .tdoEn  (tdoEn)
  );

  assign tckSel   = cfgDedicated | scanOwn;
  assign tdiSel   = cfgDedicated | scanOwn;
  assign tdoSel   = cfgDedicated | scanOwn;
  assign trstSel  = cfgTrstReserved;
  assign tapState = state;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk (
  input logic       tck,
  input logic       porN,
  input logic       trstN,
  input logic       tms,
  input logic       cfgDedicated,
  input logic       cfgTrstReserved,
  input logic       tdoEn,
  input logic       tckSel,
  input logic       tdiSel,
  input logic       tdoSel,
  input logic [3:0] tapState
);

  logic       chkRstN;
  logic [2:0] highRun;
  logic       quiet;

  assign chkRstN = porN & (trstN | ~cfgTrstReserved);

  // run of consecutive high tms samples, saturating at five
  always_ff @(posedge tck or negedge chkRstN) begin
    if (!chkRstN) begin
      highRun <= 3'd0;
      quiet   <= 1'b0;
    end else begin
      quiet <= 1'b1;
      if (!tms)                highRun <= 3'd0;
      else if (highRun < 3'd5) highRun <= highRun + 3'd1;
    end
  end

  AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!chkRstN)
    (highRun == 3'd5) |-> (tapState == 4'hF)); // R5

  AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!chkRstN)
    tdoEn |-> (tapState == 4'h2 || tapState == 4'hA)); // R9

  AST_RELEASE_IN_TLR: assert property (@(posedge tck) disable iff (!chkRstN)
    (!cfgDedicated && tapState == 4'hF) |-> !tckSel); // R4

  AST_OWN_HOLDS: assert property (@(posedge tck) disable iff (!chkRstN)
    (quiet && !cfgDedicated && $past(tckSel) && tapState != 4'hF) |-> tckSel); // R4

  AST_SELECTS_AGREE: assert property (@(posedge tck) disable iff (!chkRstN)
    (tckSel == tdiSel) && (tdiSel == tdoSel)); // R3

  AST_IDLE_HOLDS: assert property (@(posedge tck) disable iff (!chkRstN)
    (quiet && $past(tapState) == 4'hC && !$past(tms)) |-> (tapState == 4'hC)); // R2

endmodule

bind scan_port_ctrl scan_tap_chk u_chk (
  .tck             (tck),
  .porN            (porN),
  .trstN           (trstN),
  .tms             (tms),
  .cfgDedicated    (cfgDedicated),
  .cfgTrstReserved (cfgTrstReserved),
  .tdoEn           (tdoEn),
  .tckSel          (tckSel),
  .tdiSel          (tdiSel),
  .tdoSel          (tdoSel),
  .tapState        (tapState)
);

// File: tb/sim_scan_port_ctrl.sv
`timescale 1ns/1ps
module sim_scan_port_ctrl;

  localparam logic [31:0] ID_VAL = 32'h4A3790C5;

  logic       tck = 1'b0;
  logic       porN = 1'b0;
  logic       trstN = 1'b1;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       cfgDedicated = 1'b0;
  logic       cfgTrstReserved = 1'b0;
  logic       tdo, tdoEn, tckSel, tdiSel, tdoSel, trstSel;
  logic [3:0] tapState;

  int runCount = 0;
  int failCount = 0;

  always #5 tck = ~tck;

  scan_port_ctrl #(.ID_VALUE(ID_VAL)) u0 (
    .tck(tck), .porN(porN), .trstN(trstN), .tms(tms), .tdi(tdi),
    .cfgDedicated(cfgDedicated), .cfgTrstReserved(cfgTrstReserved),
    .tdo(tdo), .tdoEn(tdoEn), .tckSel(tckSel), .tdiSel(tdiSel),
    .tdoSel(tdoSel), .trstSel(trstSel), .tapState(tapState)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    runCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic tmsV, input logic tdiV);
    @(negedge tck); #1;
    tms = tmsV; tdi = tdiV;
    @(posedge tck); #1;
  endtask

  task automatic stepChk(input logic tmsV, input logic [3:0] expState, input string tag);
    tick(tmsV, 1'b0);
    chk(tapState == expState, tag, {28'd0, tapState}, {28'd0, expState});
  endtask

  task automatic shiftBits(input int n, input logic [31:0] din, output logic [31:0] dout, output bit enOk);
    dout = '0; enOk = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #1;
      dout[i] = tdo;
      if (!tdoEn) enOk = 1'b0;
      tms = (i == n - 1); tdi = din[i];
      @(posedge tck); #1;
    end
  endtask

  task automatic powerUp(input logic ded, input logic resv);
    @(negedge tck); #1;
    porN = 1'b0; tms = 1'b1; trstN = 1'b1;
    cfgDedicated = ded; cfgTrstReserved = resv;
    repeat (2) @(posedge tck);
    @(negedge tck); #1;
    porN = 1'b1;
  endtask

  task automatic testReset();
    powerUp(1'b0, 1'b0);
    #1;
    chk(tapState == 4'hF, "R1 state", {28'd0, tapState}, 32'hF);
    chk({tckSel, tdiSel, tdoSel} == 3'b000, "R1 selects", {29'd0, tckSel, tdiSel, tdoSel}, 32'd0);
    chk(tdoEn == 1'b0, "R1 tdoEn", {31'd0, tdoEn}, 32'd0);
    tick(1'b1, 1'b0);
    chk(tapState == 4'hF && !tckSel, "R3 high tms keeps user", {27'd0, tckSel, tapState}, 32'hF);
    tick(1'b0, 1'b0);
    chk({tckSel, tdiSel, tdoSel} == 3'b111, "R3 low tms claims pads", {29'd0, tckSel, tdiSel, tdoSel}, 32'd7);
  endtask

  task automatic testIdcode();
    logic [31:0] got; bit enOk;
    powerUp(1'b0, 1'b0);
    tick(1'b0, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    @(negedge tck); #1;
    chk(tdoEn == 1'b0, "R9 tdoEn low in Capture-DR", {31'd0, tdoEn}, 32'd0);
    tms = 1'b0;
    @(posedge tck); #1;
    chk(tapState == 4'h2, "R6 in Shift-DR", {28'd0, tapState}, 32'h2);
    shiftBits(32, 32'h0, got, enOk);
    chk(got == ID_VAL, "R6 idcode", got, ID_VAL);
    chk(enOk, "R9 tdoEn high in Shift-DR", {31'd0, enOk}, 32'd1);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    @(negedge tck); #1;
    chk(tdoEn == 1'b0, "R9 tdoEn low in idle", {31'd0, tdoEn}, 32'd0);
  endtask

  task automatic testWalk();
    powerUp(1'b0, 1'b0);
    stepChk(1'b0, 4'hC, "R2 Run-Test/Idle");
    stepChk(1'b1, 4'h7, "R2 Select-DR");
    stepChk(1'b0, 4'h6, "R2 Capture-DR");
    stepChk(1'b0, 4'h2, "R2 Shift-DR");
    stepChk(1'b1, 4'h1, "R2 Exit1-DR");
    stepChk(1'b0, 4'h3, "R2 Pause-DR");
    stepChk(1'b1, 4'h0, "R2 Exit2-DR");
    stepChk(1'b1, 4'h5, "R2 Update-DR");
    stepChk(1'b1, 4'h7, "R2 Select-DR again");
    stepChk(1'b1, 4'h4, "R2 Select-IR");
    stepChk(1'b0, 4'hE, "R2 Capture-IR");
    stepChk(1'b0, 4'hA, "R2 Shift-IR");
    stepChk(1'b1, 4'h9, "R2 Exit1-IR");
    stepChk(1'b0, 4'hB, "R2 Pause-IR");
    stepChk(1'b1, 4'h8, "R2 Exit2-IR");
    chk(tckSel == 1'b1, "R4 held outside reset", {31'd0, tckSel}, 32'd1);
    stepChk(1'b0, 4'hA, "R2 back to Shift-IR");
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0);
    chk(tapState != 4'hF && tckSel, "R5 four highs not enough", {27'd0, tckSel, tapState}, 32'h14);
    tick(1'b1, 1'b0);
    chk(tapState == 4'hF, "R5 fifth high reaches reset", {28'd0, tapState}, 32'hF);
    chk(!tckSel && !tdiSel && !tdoSel, "R4 released on reset entry", {29'd0, tckSel, tdiSel, tdoSel}, 32'd0);
  endtask

  task automatic testBypass();
    logic [31:0] got; bit enOk;
    powerUp(1'b0, 1'b0);
    tick(1'b0, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    shiftBits(4, 32'hF, got, enOk);
    chk(got[3:0] == 4'b0001, "R8 capture-IR pattern", got, 32'h1);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    shiftBits(8, 32'h000000B5, got, enOk);
    chk(got[7:0] == 8'h6A, "R7 bypass delays tdi by one", got, 32'h6A);
  endtask

  task automatic testTrst();
    powerUp(1'b0, 1'b1);
    chk(trstSel == 1'b1, "R10 reset pad reserved", {31'd0, trstSel}, 32'd1);
    tick(1'b0, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    @(negedge tck); #1;
    trstN = 1'b0; #1;
    chk(tapState == 4'hF, "R10 async reset state", {28'd0, tapState}, 32'hF);
    chk(!tckSel && !tdoEn, "R10 pads released, tdoEn low", {30'd0, tckSel, tdoEn}, 32'd0);
    #1 trstN = 1'b1;
    powerUp(1'b0, 1'b0);
    chk(trstSel == 1'b0, "R11 reset pad is user I/O", {31'd0, trstSel}, 32'd0);
    tick(1'b0, 1'b0);
    @(negedge tck); #1;
    trstN = 1'b0; #1;
    chk(tapState == 4'hC && tckSel, "R11 trstN ignored", {27'd0, tckSel, tapState}, 32'h1C);
    tms = 1'b1;
    @(posedge tck); #1;
    chk(tapState == 4'h7, "R11 controller keeps running", {28'd0, tapState}, 32'h7);
    trstN = 1'b1;
  endtask

  task automatic testDedicated();
    powerUp(1'b1, 1'b0);
    #1;
    chk(tapState == 4'hF && tckSel && tdiSel && tdoSel, "R12 scan-owned in reset", {25'd0, tckSel, tdiSel, tdoSel, tapState}, 32'h7F);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    chk(tapState == 4'hF && tckSel && tdiSel && tdoSel, "R12 never reverts", {25'd0, tckSel, tdiSel, tdoSel, tapState}, 32'h7F);
  endtask

  initial begin
    testReset();
    testIdcode();
    testWalk();
    testBypass();
    testTrst();
    testDedicated();
    $display("  [TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    failCount++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("  [TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

endmodule